// File: doc/BRIEF.md
# Dual-Clock FIFO with Scaled Almost Thresholds

This block is a first-in first-out buffer that joins two unrelated clock domains. A producer writes words on one clock and a consumer reads them on another. Each port's pointer lives only in its own domain. Each pointer crosses to the other side as a registered Gray code through two flip-flops. The write side computes Full and the read side computes Empty. The block offers six width/depth pairs, each holding one storage block's worth of bits. Both ports use the same width.

Two extra flags warn before the buffer runs dry or overflows. Each threshold is an 8-bit code multiplied by a step that grows with the depth of the chosen pair. A coarse code therefore covers the whole depth at every width. Parameters set several options. The active edge of each clock can be chosen. Each request strobe can be active high, active low or ignored. The thresholds can come from input pins, come from fixed parameters, or be switched off.

Top module: `dcfifo_scaled`

## Requirements
- R1: WIDTH picks the depth: 1→4096, 2→2048, 4→1024, 9→512, 18→256, 36→128. `full` is high exactly when that many words are stored. With 9-bit words it is low at 511 words and high at 512. With 36-bit words it is high at 128.
- R2: A write request while `full` is high is dropped and overwrites nothing. A read request while `empty` is high leaves `rd_data` and the read pointer unchanged.
- R3: Words leave in the order they were accepted, with none lost or repeated, while both clocks run. `rd_data` is registered. It changes only at the read-clock edge that accepts a read, and it then holds the oldest stored word.
- R4: After reset `empty` is high and `full` is low. A written word clears `empty` once its pointer has passed the two-stage synchronizer. Taking the last word sets `empty` again.
- R5: `almost_full` is high while the write-side occupancy is at or above code × STEP, where STEP = depth/16 (32 for 9-bit words, 8 for 36-bit words). With 9-bit words and a code of 8, it is low at 255 words and high at 256.
- R6: `almost_empty` is high while the read-side occupancy is at or below code × STEP. With 9-bit words and a code of 2, it is low at 65 words and high at 64.
- R7: FLAG_MODE 0 takes the codes from `ae_code`/`af_code` at run time. FLAG_MODE 1 takes them from AE_STATIC/AF_STATIC and ignores the pins. FLAG_MODE 2 holds both almost flags low.
- R8: WR_RISE and RD_RISE each choose the rising (1) or falling (0) edge of their own clock, independently of each other.
- R9: WE_POL and RE_POL each take one of three values. 1 means active high, 0 means active low, and 2 means the pin is ignored and a request is present on every cycle.
- R10: An active-low `rst_n` empties the buffer at any time. Words stored before it are never read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset to empty, active low |
| wr_en | input | 1 | Write request, polarity set by WE_POL |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | No free entry (write domain) |
| almost_full | output | 1 | Occupancy at or above the high threshold |
| rd_en | input | 1 | Read request, polarity set by RE_POL |
| rd_data | output | WIDTH | Registered read word |
| empty | output | 1 | Nothing to read (read domain) |
| almost_empty | output | 1 | Occupancy at or below the low threshold |
| ae_code | input | 8 | Low threshold code in run-time mode |
| af_code | input | 8 | High threshold code in run-time mode |

## Verification
The case that matters most is an accepted write landing in the same stretch of cycles in which the reader drains the last stored word. The Empty comparison then races against a Gray pointer that is still crossing. The bench provokes this by running both clocks at unrelated periods. It throttles the writer and the reader with different gap patterns, so the buffer keeps swinging between empty and a few words. A scoreboard judges the run: every word pushed at an accepted write must pop, in order and exactly once, at the read edge that accepts it. A premature or late `empty` shows up as a duplicate, a stale word or a missing word.

// File: rtl/dcfifo_scaled.sv
module dcfifo_scaled #(
  parameter int WIDTH     = 9,
  parameter int WR_RISE   = 1,
  parameter int RD_RISE   = 1,
  parameter int WE_POL    = 1,
  parameter int RE_POL    = 1,
  parameter int FLAG_MODE = 0,
  parameter int AE_STATIC = 2,
  parameter int AF_STATIC = 8
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             almost_full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             almost_empty,
  input  logic [7:0]       ae_code,
  input  logic [7:0]       af_code
);
  localparam int DEPTH = (WIDTH <= 1) ? 4096 : (WIDTH <= 2) ? 2048 : (WIDTH <= 4) ? 1024 :
                         (WIDTH <= 9) ? 512 : (WIDTH <= 18) ? 256 : 128;
  localparam int AW   = $clog2(DEPTH);
  localparam int STEP = DEPTH / 16;
  localparam int TW   = AW + 9;
  localparam logic [AW:0] CAP = DEPTH;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic wck, rck, wreq, rreq, wr_ok, rd_ok;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, rbin, rgray, rg_w1, rg_w2, wg_r1, wg_r2;
  logic [AW:0] wnext, rnext, wocc, rocc;
  logic [7:0]  ae_sel, af_sel;
  logic [TW-1:0] ae_thr, af_thr;

  assign wck  = (WR_RISE != 0) ? wclk : ~wclk;
  assign rck  = (RD_RISE != 0) ? rclk : ~rclk;
  assign wreq = (WE_POL == 2) ? 1'b1 : (WE_POL == 1) ? wr_en : ~wr_en;
  assign rreq = (RE_POL == 2) ? 1'b1 : (RE_POL == 1) ? rd_en : ~rd_en;

  assign wnext = wbin + 1'b1;
  assign rnext = rbin + 1'b1;
  assign full  = (wgray == {~rg_w2[AW:AW-1], rg_w2[AW-2:0]});
  assign empty = (rgray == wg_r2);
  assign wr_ok = wreq & ~full;
  assign rd_ok = rreq & ~empty;
  assign wocc  = wbin - g2b(rg_w2);
  assign rocc  = g2b(wg_r2) - rbin;

  always_ff @(posedge wck or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg_w1 <= '0; rg_w2 <= '0;
    end else begin
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      if (wr_ok) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end

  always_ff @(posedge wck)
    if (wr_ok) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge rck or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg_r1 <= '0; wg_r2 <= '0; rd_data <= '0;
    end else begin
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      if (rd_ok) begin
        rbin    <= rnext;
        rgray   <= rnext ^ (rnext >> 1);
        rd_data <= mem[rbin[AW-1:0]];
      end
    end

  assign ae_sel = (FLAG_MODE == 1) ? 8'(AE_STATIC) : ae_code;
  assign af_sel = (FLAG_MODE == 1) ? 8'(AF_STATIC) : af_code;
  assign ae_thr = TW'(ae_sel) * TW'(STEP);
  assign af_thr = TW'(af_sel) * TW'(STEP);
  assign almost_full  = (FLAG_MODE != 2) && (TW'(wocc) >= af_thr);
  assign almost_empty = (FLAG_MODE != 2) && (TW'(rocc) <= ae_thr);

  AST_NO_OVERFLOW:  assert property (@(posedge wck) disable iff (!rst_n) full && wreq |=> $stable(wbin)); // R2
  AST_FULL_AT_CAP:  assert property (@(posedge wck) disable iff (!rst_n) full |-> wocc == CAP); // R1
  AST_OCC_BOUND:    assert property (@(posedge wck) disable iff (!rst_n) wocc <= CAP); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge rck) disable iff (!rst_n) empty && rreq |=> $stable(rbin)); // R2
  AST_RDATA_HOLD:   assert property (@(posedge rck) disable iff (!rst_n) !(rreq && !empty) |=> $stable(rd_data)); // R3
endmodule

// File: tb/dcfifo_scaled_bench.sv
`timescale 1ns/100ps
module dcfifo_scaled_bench;
  logic wclk = 0, rclk = 0, rst_n = 0;
  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  int vectors = 0, errs = 0;

  // main instance: 9-bit, rising edges, active-high strobes, run-time codes
  logic m_we = 0, m_re = 0, m_full, m_af, m_empty, m_ae, m_acc = 0;
  logic [8:0] m_wd = 0, m_rd;
  logic [7:0] m_aec = 8'd2, m_afc = 8'd8;
  logic [8:0] q0[$];
  int m_pops = 0;

  dcfifo_scaled u_dcfifo_scaled (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(m_we), .wr_data(m_wd),
    .full(m_full), .almost_full(m_af), .rd_en(m_re), .rd_data(m_rd),
    .empty(m_empty), .almost_empty(m_ae), .ae_code(m_aec), .af_code(m_afc));

  // alt instance: 36-bit, falling edges, active-low strobes, static codes 3 and 15
  logic a_wn = 1, a_rn = 1, a_full, a_af, a_empty, a_ae, a_acc = 0;
  logic [35:0] a_wd = 0, a_rd;
  logic [35:0] q1[$];
  int a_pops = 0;

  dcfifo_scaled #(.WIDTH(36), .WR_RISE(0), .RD_RISE(0), .WE_POL(0), .RE_POL(0),
                  .FLAG_MODE(1), .AE_STATIC(3), .AF_STATIC(15)) u_alt (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(a_wn), .wr_data(a_wd),
    .full(a_full), .almost_full(a_af), .rd_en(a_rn), .rd_data(a_rd),
    .empty(a_empty), .almost_empty(a_ae), .ae_code(8'hFF), .af_code(8'hFF));

  // flagless instance: read strobe unused, codes 0 would otherwise raise both flags
  logic n_we = 0, n_full, n_af, n_empty, n_ae, n_acc = 0, n_re_tie = 0;
  logic [35:0] n_wd = 0, n_rd;
  logic [35:0] q2[$];
  int n_pops = 0;

  dcfifo_scaled #(.WIDTH(36), .RE_POL(2), .FLAG_MODE(2)) u_nf (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(n_we), .wr_data(n_wd),
    .full(n_full), .almost_full(n_af), .rd_en(n_re_tie), .rd_data(n_rd),
    .empty(n_empty), .almost_empty(n_ae), .ae_code(8'd0), .af_code(8'd0));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // write-side capture of accepted words
  always @(posedge wclk) begin
    if (rst_n && m_we && !m_full) q0.push_back(m_wd);
    if (rst_n && n_we && !n_full) q2.push_back(n_wd);
  end
  always @(negedge wclk)
    if (rst_n && !a_wn && !a_full) q1.push_back(a_wd);

  // read-side monitors
  always @(posedge rclk) begin
    m_acc <= rst_n && m_re && !m_empty;
    n_acc <= rst_n && !n_empty;
  end
  always @(negedge rclk) a_acc <= rst_n && !a_rn && !a_empty;

  always @(negedge rclk) begin
    if (m_acc) begin
      m_pops++;
      if (q0.size() == 0) chk("R2 main read with nothing stored", 1, 0);
      else chk("R3 main data order", m_rd, q0.pop_front());
    end
    if (n_acc) begin
      n_pops++;
      if (q2.size() == 0) chk("R2 flagless read with nothing stored", 1, 0);
      else chk("R9 flagless data with read strobe unused", n_rd, q2.pop_front());
    end
  end
  always @(posedge rclk)
    if (a_acc) begin
      a_pops++;
      if (q1.size() == 0) chk("R2 alt read with nothing stored", 1, 0);
      else chk("R8 alt data on falling edges", a_rd, q1.pop_front());
    end

  task automatic m_write(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk); m_we = 1; m_wd = 9'(i * 5 + seed);
    end
    @(negedge wclk); m_we = 0;
  endtask

  task automatic m_read1();
    @(negedge rclk); m_re = 1;
    @(negedge rclk); m_re = 0;
  endtask

  task automatic a_write(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(posedge wclk); a_wn = 0; a_wd = 36'(i * 36'h101_0101) ^ 36'(seed);
    end
    @(posedge wclk); a_wn = 1;
  endtask

  initial begin
    #800000;
    errs++; vectors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    logic [8:0] hold;
    bit wdone;
    #49.5 rst_n = 1;
    #10;
    // R4 reset state, R7 modes
    chk("R4 empty after reset", m_empty, 1);
    chk("R4 full low after reset", m_full, 0);
    chk("R6 almost_empty at zero occupancy", m_ae, 1);
    chk("R5 almost_full low at zero", m_af, 0);
    chk("R4 alt empty after reset", a_empty, 1);
    chk("R7 static mode alt almost_empty", a_ae, 1);
    chk("R7 mode off: almost_full held low", n_af, 0);
    chk("R7 mode off: almost_empty held low", n_ae, 0);

    // R1/R5 fill the main instance
    m_write(255, 1);
    chk("R5 almost_full low at 255", m_af, 0);
    m_write(1, 256);
    chk("R5 almost_full high at 256", m_af, 1);
    m_write(255, 7);
    chk("R1 full low at 511", m_full, 0);
    m_write(1, 300);
    chk("R1 full high at 512", m_full, 1);
    // R2 write while full
    @(negedge wclk); m_we = 1; m_wd = 9'h1AA;
    @(negedge wclk); m_we = 0;
    chk("R2 full holds after dropped write", m_full, 1);
    chk("R2 no word queued by dropped write", q0.size(), 512);

    // R6 drain with boundaries
    repeat (5) @(negedge rclk);
    for (int i = 0; i < 447; i++) m_read1();
    chk("R6 almost_empty low at 65", m_ae, 0);
    m_read1();
    chk("R6 almost_empty high at 64", m_ae, 1);
    for (int i = 0; i < 64; i++) m_read1();
    repeat (2) @(negedge rclk);
    chk("R4 empty after last read", m_empty, 1);
    chk("R3 every stored word read", m_pops, 512);
    hold = m_rd;
    m_read1();
    repeat (2) @(negedge rclk);
    chk("R2 read while empty keeps rd_data", m_rd, hold);
    chk("R2 read while empty pops nothing", m_pops, 512);

    // concurrent write and drain
    m_pops = 0; wdone = 0;
    fork
      begin
        for (int i = 0; i < 400; i++) begin
          @(negedge wclk); m_we = 1; m_wd = 9'(i * 37 + 3);
          if (i % 5 == 3) begin @(negedge wclk); m_we = 0; end
        end
        @(negedge wclk); m_we = 0;
        wdone = 1;
      end
      begin
        int k = 0;
        while (!(wdone && m_pops == 400)) begin
          @(negedge rclk); m_re = (k % 4 != 1); k++;
        end
        m_re = 0;
      end
    join
    repeat (4) @(negedge rclk);
    chk("R3 concurrent run count", m_pops, 400);
    chk("R4 empty after concurrent run", m_empty, 1);

    // R7 run-time code change
    @(negedge wclk); m_afc = 8'd0;
    #0.5 chk("R7 run-time af_code 0 raises almost_full", m_af, 1);
    m_afc = 8'd8;
    #0.5 chk("R7 run-time af_code 8 lowers almost_full", m_af, 0);

    // R10 reset with contents
    m_write(10, 40);
    repeat (5) @(negedge rclk);
    chk("R4 empty clears after sync", m_empty, 0);
    @(negedge wclk); #0.5 rst_n = 0;
    #0.5 chk("R10 reset empties main", m_empty, 1);
    chk("R10 reset clears full", m_full, 0);
    q0.delete(); q1.delete(); q2.delete();
    #20.5 rst_n = 1;
    m_pops = 0;
    m_write(1, 171);
    repeat (5) @(negedge rclk);
    m_read1();
    repeat (2) @(negedge rclk);
    chk("R10 only the post-reset word returns", m_pops, 1);
    chk("R10 main empty again", m_empty, 1);

    // R8/R9/R7 alt instance
    a_write(24, 36'h5A);
    repeat (6) @(posedge rclk);
    chk("R7 static AE code 3 high at 24", a_ae, 1);
    a_write(1, 36'h77);
    repeat (6) @(posedge rclk);
    chk("R7 static AE code 3 low at 25", a_ae, 0);
    a_write(94, 36'h3C);
    chk("R7 static AF code 15 low at 119", a_af, 0);
    a_write(1, 36'h11);
    chk("R7 static AF code 15 high at 120", a_af, 1);
    a_write(8, 36'h99);
    chk("R1 alt full at 128", a_full, 1);
    @(posedge rclk); a_rn = 0;
    repeat (140) @(posedge rclk);
    a_rn = 1;
    repeat (3) @(posedge rclk);
    chk("R9 active-low read drained all", a_pops, 128);
    chk("R4 alt empty after drain", a_empty, 1);

    // R9 unused read strobe, R7 flags off
    for (int i = 0; i < 5; i++) begin
      @(negedge wclk); n_we = 1; n_wd = 36'(i * 36'h7_0000_0003 + 5);
    end
    @(negedge wclk); n_we = 0;
    chk("R7 off mode flags low with data", {n_af, n_ae}, 0);
    repeat (20) @(negedge rclk);
    chk("R9 unused strobe reads all", n_pops, 5);
    chk("R4 flagless empty", n_empty, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule